// File: doc/BRIEF.md
# Paged Coefficient Store with Command Decode

This block keeps the filter weights and the operating configuration for a small image-filter engine. It holds four pages of nine signed 8-bit weights, arranged as a 3x3 grid per page, plus a configuration register. The register has a 3-bit operating mode/format code, a 3-bit output-limit code and a 1-bit rounding-position flag. Everything is programmed through two 8-bit ports, a command/address byte and a data byte, while an active-low load enable is held low.

The command byte carries four things. Bit 7 is a chip-select that must be low for any write. Bits 5:4 give the page. Bits 3:2 give the grid row and bits 1:0 the grid column, each counted from zero. The location code 1111 selects the configuration register instead. Every other location code, and any cycle with the load enable high, leaves all state untouched.

When the load enable is seen rising on a clock edge, the block emits a one-cycle resync pulse. This pulse restarts the engine's three-cycle data sequence, even when nothing was written. The engine reads one whole page at a time through a 2-bit page select.

Top module: `coef_page_store`

## Requirements
- R1: During and after a synchronous reset, every weight of every page reads zero, the mode, limit and rounding outputs are zero, and resync is low.
- R2: A clock edge that samples load_n=0, cmd_addr[7]=0, row field cmd_addr[3:2] below 3 and column field cmd_addr[1:0] below 3 writes cmd_data into page cmd_addr[5:4] at that row and column. No other weight changes.
- R3: A clock edge that samples load_n=0 with cmd_addr[7]=1 changes no weight and no configuration field.
- R4: A clock edge that samples load_n=1 changes no weight and no configuration field, whatever the command and data bytes hold.
- R5: With load_n=0 and cmd_addr[7]=0, a location code whose row field or column field equals 3, other than 1111, changes no weight and no configuration field.
- R6: With load_n=0, cmd_addr[7]=0, cmd_addr[3:0]=1111 and cmd_data[7]=0, the edge loads mode_sel from cmd_data[2:0], limit_sel from cmd_data[5:3] and round_full from cmd_data[6]. No weight changes.
- R7: A configuration write whose cmd_data[7]=1 leaves mode_sel, limit_sel and round_full unchanged.
- R8: resync is high for exactly the one cycle after an edge that samples load_n=1 when the previous edge sampled load_n=0. This holds regardless of cmd_addr[7]. A steady load_n gives no pulse.
- R9: rd_coefs shows page rd_page combinationally, with the weight for row r and column c (both 0..2) at bits [8*(3r+c)+7 : 8*(3r+c)]. A write to the displayed page appears after the writing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low load enable; its rising edge resynchronises |
| cmd_addr | input | 8 | Command byte: chip-select, page, location code |
| cmd_data | input | 8 | Weight value or configuration byte |
| rd_page | input | 2 | Page shown on rd_coefs |
| rd_coefs | output | 72 | Nine weights of the selected page, row-major |
| mode_sel | output | 3 | Operating mode and data format code |
| limit_sel | output | 3 | Output limit format code |
| round_full | output | 1 | Rounding position: 0 half-LSB, 1 full-LSB |
| resync | output | 1 | One-cycle pulse after a load_n rising edge |

## Verification
A weight or configuration write is due on the outputs in the cycle after the single edge that samples it, because one register stage sits between the ports and rd_coefs or the configuration outputs. A change of rd_page alone is due within the same cycle, with no edge at all. The resync pulse is due in the cycle after the edge that first samples load_n high, and must be gone one cycle later. The bench drives every input on the falling edge and reads results on the next falling edge, or a nanosecond after a rd_page change. Each read therefore falls exactly one register stage, or zero stages, after its stimulus.

// File: rtl/coef_store_pkg.sv
`timescale 1ns/1ps
package coef_store_pkg;

  localparam int COEF_W_DEF    = 8;
  localparam int NUM_PAGES_DEF = 4;
  localparam int ROWS_DEF      = 3;
  localparam int COLS_DEF      = 3;

  // Command byte layout; the decode depends on these positions.
  localparam int CS_BIT      = 7;
  localparam int PAGE_LSB    = 4;
  localparam int ROW_LSB     = 2;
  localparam int COL_LSB     = 0;
  localparam int FIELD_W     = 2;
  localparam logic [3:0] CTRL_CODE = 4'b1111;

  // Configuration byte layout.
  localparam int KEEP_BIT    = 7;
  localparam int ROUND_BIT   = 6;

  typedef struct packed {
    logic [2:0] mode;
    logic [2:0] limit;
    logic       round_full;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mode: 3'd0, limit: 3'd0, round_full: 1'b0};

endpackage

// File: rtl/coef_cmd_decode.sv
`timescale 1ns/1ps
module coef_cmd_decode
  import coef_store_pkg::*;
#(
  parameter int ROWS   = ROWS_DEF,
  parameter int COLS   = COLS_DEF,
  parameter int PAGE_W = 2
)(
  input  logic               load_n,
  input  logic [7:0]         cmd_addr,
  output logic               coef_we,
  output logic               ctrl_we,
  output logic [PAGE_W-1:0]  wr_page,
  output logic [FIELD_W-1:0] wr_row,
  output logic [FIELD_W-1:0] wr_col
);

  logic selected;
  logic is_ctrl;
  logic loc_ok;
  logic unused_bit6;

  assign unused_bit6 = cmd_addr[6];

  always_comb begin
    wr_page  = cmd_addr[PAGE_LSB +: PAGE_W];
    wr_row   = cmd_addr[ROW_LSB +: FIELD_W];
    wr_col   = cmd_addr[COL_LSB +: FIELD_W];
    selected = !load_n && !cmd_addr[CS_BIT];
    is_ctrl  = (cmd_addr[3:0] == CTRL_CODE);
    loc_ok   = (int'(wr_row) < ROWS) && (int'(wr_col) < COLS);
    coef_we  = selected && !is_ctrl && loc_ok;
    ctrl_we  = selected && is_ctrl;
  end

endmodule

// File: rtl/coef_bank.sv
`timescale 1ns/1ps
module coef_bank
  import coef_store_pkg::*;
#(
  parameter int COEF_W    = COEF_W_DEF,
  parameter int NUM_PAGES = NUM_PAGES_DEF,
  parameter int ROWS      = ROWS_DEF,
  parameter int COLS      = COLS_DEF,
  parameter int PAGE_W    = $clog2(NUM_PAGES)
)(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [PAGE_W-1:0]             wr_page,
  input  logic [FIELD_W-1:0]            wr_row,
  input  logic [FIELD_W-1:0]            wr_col,
  input  logic [COEF_W-1:0]             wr_data,
  input  logic [PAGE_W-1:0]             rd_page,
  output logic [ROWS*COLS*COEF_W-1:0]   rd_coefs
);

  localparam int TAPS  = ROWS * COLS;
  localparam int DEPTH = NUM_PAGES * TAPS;
  localparam int IDX_W = $clog2(DEPTH);

  logic [COEF_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wr_idx;

  always_comb
    wr_idx = IDX_W'(int'(wr_page) * TAPS + int'(wr_row) * COLS + int'(wr_col));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_lane
    logic [IDX_W-1:0] rd_idx;
    assign rd_idx = IDX_W'(int'(rd_page) * TAPS + t);
    assign rd_coefs[t*COEF_W +: COEF_W] = mem[rd_idx];
  end

endmodule

// File: rtl/coef_cfg_reg.sv
`timescale 1ns/1ps
module coef_cfg_reg
  import coef_store_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [7:0] cfg_byte,
  output cfg_t       cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (ctrl_we && !cfg_byte[KEEP_BIT]) begin
      cfg.mode       <= cfg_byte[2:0];
      cfg.limit      <= cfg_byte[5:3];
      cfg.round_full <= cfg_byte[ROUND_BIT];
    end
  end

endmodule

// File: rtl/coef_resync_gen.sv
`timescale 1ns/1ps
module coef_resync_gen (
  input  logic clk,
  input  logic rst,
  input  logic load_n,
  output logic resync
);

  logic load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= 1'b1;
      resync <= 1'b0;
    end else begin
      load_q <= load_n;
      resync <= load_n && !load_q;
    end
  end

endmodule

// File: rtl/coef_page_store.sv
`timescale 1ns/1ps
module coef_page_store
  import coef_store_pkg::*;
#(
  parameter int COEF_W    = COEF_W_DEF,
  parameter int NUM_PAGES = NUM_PAGES_DEF,
  parameter int ROWS      = ROWS_DEF,
  parameter int COLS      = COLS_DEF,
  parameter int PAGE_W    = $clog2(NUM_PAGES)
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_n,
  input  logic [7:0]                  cmd_addr,
  input  logic [COEF_W-1:0]           cmd_data,
  input  logic [PAGE_W-1:0]           rd_page,
  output logic [ROWS*COLS*COEF_W-1:0] rd_coefs,
  output logic [2:0]                  mode_sel,
  output logic [2:0]                  limit_sel,
  output logic                        round_full,
  output logic                        resync
);

  logic               coef_we;
  logic               ctrl_we;
  logic [PAGE_W-1:0]  wr_page;
  logic [FIELD_W-1:0] wr_row;
  logic [FIELD_W-1:0] wr_col;
  cfg_t               cfg;

  coef_cmd_decode #(
    .ROWS(ROWS), .COLS(COLS), .PAGE_W(PAGE_W)
  ) u_decode (
    .load_n(load_n), .cmd_addr(cmd_addr),
    .coef_we(coef_we), .ctrl_we(ctrl_we),
    .wr_page(wr_page), .wr_row(wr_row), .wr_col(wr_col)
  );

  coef_bank #(
    .COEF_W(COEF_W), .NUM_PAGES(NUM_PAGES), .ROWS(ROWS), .COLS(COLS), .PAGE_W(PAGE_W)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(coef_we),
    .wr_page(wr_page), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(cmd_data), .rd_page(rd_page), .rd_coefs(rd_coefs)
  );

  coef_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we),
    .cfg_byte(8'(cmd_data)), .cfg(cfg)
  );

  coef_resync_gen u_resync (
    .clk(clk), .rst(rst), .load_n(load_n), .resync(resync)
  );

  assign mode_sel   = cfg.mode;
  assign limit_sel  = cfg.limit;
  assign round_full = cfg.round_full;

endmodule

// File: rtl/coef_store_checker.sv
`timescale 1ns/1ps
module coef_store_checker #(
  parameter int COEF_W = 8,
  parameter int TAPS   = 9,
  parameter int PAGE_W = 2
)(
  input logic                   clk,
  input logic                   rst,
  input logic                   load_n,
  input logic [7:0]             cmd_addr,
  input logic [COEF_W-1:0]      cmd_data,
  input logic [PAGE_W-1:0]      rd_page,
  input logic [TAPS*COEF_W-1:0] rd_coefs,
  input logic [2:0]             mode_sel,
  input logic [2:0]             limit_sel,
  input logic                   round_full,
  input logic                   resync
);

  logic [6:0] cfg_now;
  assign cfg_now = {mode_sel, limit_sel, round_full};

  // Checker-side record of the last weight write.
  logic              prev_wr;
  logic [PAGE_W-1:0] prev_page;
  int                prev_lane;
  logic [COEF_W-1:0] prev_data;
  logic [COEF_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_wr   <= 1'b0;
      prev_page <= '0;
      prev_lane <= 0;
      prev_data <= '0;
    end else begin
      prev_wr   <= !load_n && !cmd_addr[7] && cmd_addr[3:2] != 2'b11 && cmd_addr[1:0] != 2'b11;
      prev_page <= cmd_addr[4 +: PAGE_W];
      prev_lane <= 3 * int'(cmd_addr[3:2]) + int'(cmd_addr[1:0]);
      prev_data <= cmd_data;
    end
  end

  always_comb seen = rd_coefs[prev_lane*COEF_W +: COEF_W];

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_now == '0 && !resync && rd_coefs == '0));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (prev_wr && rd_page == prev_page) |-> seen == prev_data);

  assert_cs_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_n) && $past(cmd_addr[7]) && $stable(rd_page))
      |-> ($stable(rd_coefs) && $stable(cfg_now)));

  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_n) && $stable(rd_page))
      |-> ($stable(rd_coefs) && $stable(cfg_now)));

  assert_hold_code_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_n) && !$past(cmd_addr[7]) && $stable(rd_page) &&
     $past(cmd_addr[3:2] == 2'b11 || cmd_addr[1:0] == 2'b11) && $past(cmd_addr[3:0] != 4'hF))
      |-> ($stable(rd_coefs) && $stable(cfg_now)));

  assert_ctrl_load_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_n) && !$past(cmd_addr[7]) &&
     $past(cmd_addr[3:0]) == 4'hF && !$past(cmd_data[7]))
      |-> (mode_sel == $past(cmd_data[2:0]) && limit_sel == $past(cmd_data[5:3]) &&
           round_full == $past(cmd_data[6])));

  assert_ctrl_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_addr[3:0]) == 4'hF && $past(cmd_data[7]))
      |-> $stable(cfg_now));

  assert_resync_width_R8: assert property (@(posedge clk) disable iff (rst)
    resync |=> !resync);

  assert_resync_cause_R8: assert property (@(posedge clk) disable iff (rst)
    resync |-> ($past(load_n) && !$past(load_n, 2)));

endmodule

bind coef_page_store coef_store_checker u_chk (.*);

// File: tb/sim_coef_page_store.sv
`timescale 1ns/1ps
module sim_coef_page_store;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_n = 1'b1;
  logic [7:0]  cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic [1:0]  rd_page = '0;
  logic [71:0] rd_coefs;
  logic [2:0]  mode_sel;
  logic [2:0]  limit_sel;
  logic        round_full;
  logic        resync;

  int errors = 0;
  int checks = 0;

  logic [7:0] exp_w [4][3][3];
  logic [2:0] exp_mode = '0;
  logic [2:0] exp_limit = '0;
  logic       exp_round = 1'b0;

  always #10 clk = ~clk;

  coef_page_store u0 (
    .clk(clk), .rst(rst), .load_n(load_n), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_page(rd_page), .rd_coefs(rd_coefs), .mode_sel(mode_sel), .limit_sel(limit_sel),
    .round_full(round_full), .resync(resync)
  );

  function automatic logic [71:0] packed_page(input int p);
    logic [71:0] v = '0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        v[8*(3*r+c) +: 8] = exp_w[p][r][c];
    return v;
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Drive one command for one edge and update the model from the requirements.
  task automatic drive(input logic ln, input logic [7:0] d, input logic [7:0] e);
    load_n = ln; cmd_addr = d; cmd_data = e;
    cyc();
    if (!ln && !d[7]) begin
      if (d[3:0] == 4'hF) begin
        if (!e[7]) begin exp_mode = e[2:0]; exp_limit = e[5:3]; exp_round = e[6]; end
      end else if (d[3:2] != 2'b11 && d[1:0] != 2'b11) begin
        exp_w[d[5:4]][d[3:2]][d[1:0]] = e;
      end
    end
  endtask

  task automatic check_pages(input string req);
    for (int p = 0; p < 4; p++) begin
      rd_page = 2'(p);
      #1;
      check(req, rd_coefs, packed_page(p));
    end
  endtask

  task automatic check_cfg(input string req);
    check(req, {65'd0, mode_sel, limit_sel, round_full}, {65'd0, exp_mode, exp_limit, exp_round});
  endtask

  // Raise load_n and expect exactly one resync cycle.
  task automatic release_load(input string req);
    drive(1'b1, 8'h00, 8'h00);
    check(req, {71'd0, resync}, 72'd1);
    cyc();
    check(req, {71'd0, resync}, 72'd0);
  endtask

  task automatic t_reset();
    check_pages("R1 weights zero");
    check_cfg("R1 config zero");
    check("R1 resync low", {71'd0, resync}, 72'd0);
  endtask

  task automatic t_grid_write();
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        drive(1'b0, {2'b00, 2'd1, 2'(r), 2'(c)}, 8'(8'h10 + 16*r + c));
    drive(1'b0, {2'b00, 2'd3, 2'd1, 2'd2}, 8'h9C);
    drive(1'b0, {2'b00, 2'd3, 2'd0, 2'd0}, 8'h81);
    check_pages("R2 grid order and page isolation");
    release_load("R8 pulse after write burst");
  endtask

  task automatic t_read_select();
    rd_page = 2'd1; #1;
    check("R9 page 1 combinational", rd_coefs, packed_page(1));
    rd_page = 2'd3; #1;
    check("R9 page 3 combinational", rd_coefs, packed_page(3));
    drive(1'b0, {2'b00, 2'd3, 2'd2, 2'd2}, 8'h5A);
    check("R9 write to shown page visible after edge", rd_coefs, packed_page(3));
    release_load("R8 pulse after single write");
  endtask

  task automatic t_chip_select();
    drive(1'b0, {2'b10, 2'd1, 2'd0, 2'd0}, 8'hEE);
    drive(1'b0, 8'b1000_1111, 8'h7F);
    check_pages("R3 chip-select high blocks weight write");
    check_cfg("R3 chip-select high blocks config write");
    release_load("R8 resync without write");
  endtask

  task automatic t_hold_codes();
    logic [3:0] codes [6] = '{4'b0011, 4'b0111, 4'b1011, 4'b1100, 4'b1101, 4'b1110};
    for (int i = 0; i < 6; i++)
      drive(1'b0, {4'b0001, codes[i]}, 8'hA5);
    check_pages("R5 hold codes write nothing");
    check_cfg("R5 hold codes leave config");
    release_load("R8 pulse after hold codes");
  endtask

  task automatic t_load_high();
    drive(1'b1, {2'b00, 2'd1, 2'd1, 2'd1}, 8'h33);
    drive(1'b1, 8'h0F, 8'h7F);
    check_pages("R4 load high writes no weight");
    check_cfg("R4 load high writes no config");
    check("R8 no pulse while load high", {71'd0, resync}, 72'd0);
  endtask

  task automatic t_control();
    drive(1'b0, 8'h0F, {1'b0, 1'b1, 3'b011, 3'b101});
    check_cfg("R6 config loaded");
    check_pages("R6 config write leaves weights");
    drive(1'b0, 8'h3F, {1'b1, 1'b0, 3'b110, 3'b010});
    check_cfg("R7 keep bit leaves config");
    drive(1'b0, 8'h2F, {1'b0, 1'b0, 3'b100, 3'b111});
    check_cfg("R6 second config load");
    release_load("R8 pulse after config");
  endtask

  task automatic t_resync_long();
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 8'h80, 8'h00);
      check("R8 no pulse while load low", {71'd0, resync}, 72'd0);
    end
    release_load("R8 single pulse after long low");
    cyc();
    check("R8 no repeat pulse", {71'd0, resync}, 72'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          exp_w[p][r][c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc();
    t_reset();
    t_grid_write();
    t_read_select();
    t_chip_select();
    t_hold_codes();
    t_load_high();
    t_control();
    t_resync_long();
    finish_run();
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule